// File: doc/BRIEF.md
# ADC conversion mode sequencer

This block is the digital controller that sits in front of a successive-approximation converter. The converter is modelled as a handshake. The sequencer sends a one-cycle start pulse together with a channel number. After its conversion time the converter returns a one-cycle done strobe with a result word. Software drives the block through a few write strobes: a control word, a channel number and an end-of-conversion clear. It reads results back through a registered read port.

The control word carries a power/start bit, a continuous bit, a scan bit, a buffer-enable bit and an interrupt enable. The first write that sets the power bit only powers up the converter. The first start after that waits out a stabilization window before it launches. Later starts launch at once. The block runs five conversion patterns:

- single
- continuous
- buffered continuous, which fills a ten-entry buffer from one channel
- single scan, over channels 0 to n
- continuous scan

Single results go to a data register and buffered or scan results go to the buffer. The block raises an end-of-conversion flag and an interrupt. It also flags an overrun when an unread buffer entry is overwritten.

Top module: `adc_mode_sequencer`

## Requirements
- R1: After reset the block is powered down, and `eoc`, `ovr`, `irq`, `adc_start` and `cur_chan` are all 0.
- R2: Control word bits are: bit0 power/start, bit1 continuous, bit2 scan, bit3 buffer enable, bit4 interrupt enable. A write with bit0=1 while powered down only powers up and launches nothing. The next such write opens a STAB_CYCLES (14) cycle window, and `adc_start` pulses 14 cycles after that write. Further start writes during the window launch nothing extra.
- R3: Once stabilized, a start write while the block is idle pulses `adc_start` in the cycle after the write.
- R4: In single mode a done strobe stores `adc_result` in the data register, which is read at `rd_addr` 15. The same strobe sets `eoc`, and `irq` equals `eoc` AND the interrupt enable bit.
- R5: With the continuous bit set and no scan or buffer mode, a new conversion launches after each one. Clearing the continuous bit stops the block after the conversion in flight. A write with bit0=0 stops it at once: no further `adc_start` pulses occur and no later result sets `eoc`.
- R6: In buffered mode with continuous set, ten conversions of the selected channel fill buffer entries 0 to 9, which are read at `rd_addr` 0 to 9. `eoc` rises only on the tenth result, and a new fill then begins automatically.
- R7: In scan mode channels 0 to n are converted in order, where n is the channel number at launch (clamped to 9). Entry k holds the result of channel k. `cur_chan` shows the channel under conversion. `eoc` rises after channel n, giving exactly n+1 conversions.
- R8: In continuous scan a new pass begins at channel 0 after channel n. Clearing the continuous bit mid-pass stops the block after channel n.
- R9: Outside scan mode, writing a different channel while a conversion is in flight abandons it and re-pulses `adc_start` on the new channel. The stored result then comes from the new channel.
- R10: Each buffer entry is marked unread when written and cleared when read. Writing an unread entry sets `ovr`, and any control write with bit0=1 clears `ovr`.
- R11: A pulse on `eoc_clr` clears `eoc`, and with it `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: power/start, continuous, scan, buffer, interrupt enable |
| chan_we | input | 1 | Channel write strobe |
| chan_wdata | input | CH_W | Channel number (scan end channel in scan mode) |
| eoc_clr | input | 1 | Clears the end-of-conversion flag |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | 0 to 9 buffer entries, 15 data register |
| rd_data | output | RES_W | Read data, valid the cycle after `rd_en` |
| eoc | output | 1 | End-of-conversion flag |
| ovr | output | 1 | Overrun flag |
| irq | output | 1 | End-of-conversion interrupt |
| cur_chan | output | CH_W | Channel being converted or selected |
| adc_start | output | 1 | One-cycle start pulse to the converter |
| adc_done | input | 1 | Converter done strobe |
| adc_result | input | RES_W | Converter result, valid with `adc_done` |

## Verification
If the sequence state is wrong, the count of `adc_start` pulses between two `eoc` rises is wrong, or the order of `cur_chan` values is wrong. Either shows within one pass, 15 to 150 cycles. A bad stabilization flag moves the first start pulse by 14 cycles, which is seen right after the start write. Broken unread flags show as a wrong `ovr` level after the second buffered or scan pass. Reading the entries back shows a wrong channel field at once.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_IDLE, ST_STAB, ST_CONV} seq_state_e;
  typedef enum logic [1:0] {MD_SINGLE, MD_BUFFER, MD_SCAN} run_mode_e;
  typedef struct packed {
    logic ie;
    logic bufm;
    logic scan;
    logic cont;
  } seq_cfg_t;
endpackage

// File: rtl/adcseq_stab_timer.sv
module adcseq_stab_timer #(
  parameter int CYCLES = 14,
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clear,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign done = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (clear) begin
      run_q <= 1'b0;
    end else if (load) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_STAB_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done && !load |=> !done); // R2
endmodule

// File: rtl/adcseq_result_buf.sv
module adcseq_result_buf #(
  parameter int DEPTH = 10,
  parameter int WIDTH = 10,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata,
  output logic             overwrite
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] unread_q;

  assign overwrite = we && unread_q[waddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unread_q <= '0;
    end else begin
      if (re) unread_q[raddr] <= 1'b0;
      if (we) unread_q[waddr] <= 1'b1;
    end
  end

  AST_UNREAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> unread_q[$past(waddr)]); // R10
endmodule

// File: rtl/adc_mode_sequencer.sv
module adc_mode_sequencer
  import adcseq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int CH_W        = 4,
  parameter int BUF_DEPTH   = 10,
  parameter int STAB_CYCLES = 14,
  localparam int ADDR_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [4:0]        ctl_wdata,
  input  logic              chan_we,
  input  logic [CH_W-1:0]   chan_wdata,
  input  logic              eoc_clr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RES_W-1:0]  rd_data,
  output logic              eoc,
  output logic              ovr,
  output logic              irq,
  output logic [CH_W-1:0]   cur_chan,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_result
);
  localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam logic [ADDR_W-1:0] DR_ADDR  = '1;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BUF_DEPTH - 1);
  localparam logic [CH_W-1:0]   LAST_CH  = CH_W'(BUF_DEPTH - 1);

  seq_state_e       state_q;
  run_mode_e        mode_q;
  seq_cfg_t         cfg_q, cfg_n;
  logic [CH_W-1:0]  chan_q, cur_ch_q, end_ch_q;
  logic [IDX_W-1:0] idx_q;
  logic             stable_q, start_q, eoc_q, ovr_q;
  logic [RES_W-1:0] dr_q, rd_dr_q, buf_rdata;
  logic             rd_dr_sel_q;

  logic ctl_start, ctl_off, stab_load, stab_done, launch, abort;
  logic conv_done, seq_last, eoc_set, buf_we, buf_re, buf_ovwr;
  logic [IDX_W-1:0] buf_waddr;

  always_comb begin
    cfg_n     = ctl_we ? seq_cfg_t'(ctl_wdata[4:1]) : cfg_q;
    ctl_start = ctl_we && ctl_wdata[0];
    ctl_off   = ctl_we && !ctl_wdata[0];
    stab_load = (state_q == ST_IDLE) && ctl_start && !stable_q;
    launch    = !ctl_off && (((state_q == ST_IDLE) && ctl_start && stable_q) ||
                             ((state_q == ST_STAB) && stab_done));
    abort     = (state_q == ST_CONV) && chan_we && (mode_q != MD_SCAN) &&
                (chan_wdata != cur_ch_q) && !ctl_off;
    conv_done = (state_q == ST_CONV) && adc_done && !abort && !ctl_off;
    unique case (mode_q)
      MD_BUFFER: seq_last = (idx_q == LAST_IDX);
      MD_SCAN:   seq_last = (cur_ch_q == end_ch_q);
      default:   seq_last = 1'b1;
    endcase
    eoc_set   = conv_done && seq_last;
    buf_we    = conv_done && (mode_q != MD_SINGLE);
    buf_waddr = (mode_q == MD_SCAN) ? IDX_W'(cur_ch_q) : idx_q;
    buf_re    = rd_en && (rd_addr < ADDR_W'(BUF_DEPTH));
  end

  adcseq_stab_timer #(.CYCLES(STAB_CYCLES)) u_stab (
    .clk(clk), .rst(rst), .load(stab_load), .clear(ctl_off), .done(stab_done)
  );

  adcseq_result_buf #(.DEPTH(BUF_DEPTH), .WIDTH(RES_W)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .waddr(buf_waddr), .wdata(adc_result),
    .re(buf_re), .raddr(IDX_W'(rd_addr)), .rdata(buf_rdata), .overwrite(buf_ovwr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      mode_q   <= MD_SINGLE;
      cfg_q    <= '0;
      chan_q   <= '0;
      cur_ch_q <= '0;
      end_ch_q <= '0;
      idx_q    <= '0;
      stable_q <= 1'b0;
      start_q  <= 1'b0;
      eoc_q    <= 1'b0;
      ovr_q    <= 1'b0;
      dr_q     <= '0;
    end else begin
      start_q <= 1'b0;
      cfg_q   <= cfg_n;
      if (eoc_set) eoc_q <= 1'b1;
      else if (eoc_clr) eoc_q <= 1'b0;
      if (ctl_start) ovr_q <= 1'b0;
      else if (buf_ovwr) ovr_q <= 1'b1;
      if (chan_we) begin
        chan_q <= chan_wdata;
        if (!((state_q == ST_CONV) && (mode_q == MD_SCAN))) cur_ch_q <= chan_wdata;
      end
      if (ctl_off) begin
        state_q  <= ST_OFF;
        stable_q <= 1'b0;
      end else if (state_q == ST_OFF && ctl_start) begin
        state_q <= ST_IDLE;
      end else if (stab_load) begin
        state_q <= ST_STAB;
      end else if (launch) begin
        state_q  <= ST_CONV;
        stable_q <= 1'b1;
        start_q  <= 1'b1;
        idx_q    <= '0;
        end_ch_q <= (chan_q > LAST_CH) ? LAST_CH : chan_q;
        if (cfg_n.scan) begin
          mode_q   <= MD_SCAN;
          cur_ch_q <= '0;
        end else begin
          mode_q   <= cfg_n.bufm ? MD_BUFFER : MD_SINGLE;
          cur_ch_q <= chan_q;
        end
      end else if (abort) begin
        start_q <= 1'b1;
      end else if (conv_done) begin
        if (mode_q == MD_SINGLE) dr_q <= adc_result;
        if (seq_last) begin
          idx_q <= '0;
          if (cfg_q.cont) begin
            start_q <= 1'b1;
            if (mode_q == MD_SCAN) cur_ch_q <= '0;
          end else begin
            state_q <= ST_IDLE;
          end
        end else begin
          start_q <= 1'b1;
          if (mode_q == MD_SCAN) cur_ch_q <= cur_ch_q + 1'b1;
          else idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_dr_sel_q <= 1'b0;
      rd_dr_q     <= '0;
    end else if (rd_en) begin
      rd_dr_sel_q <= (rd_addr == DR_ADDR);
      if (rd_addr == DR_ADDR) rd_dr_q <= dr_q;
    end
  end

  assign rd_data   = rd_dr_sel_q ? rd_dr_q : buf_rdata;
  assign eoc       = eoc_q;
  assign ovr       = ovr_q;
  assign irq       = eoc_q && cfg_q.ie;
  assign cur_chan  = cur_ch_q;
  assign adc_start = start_q;

  AST_STAB_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    stab_done |-> state_q == ST_STAB); // R2
  AST_EOC_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc_q) |-> $past(adc_done)); // R4
  AST_SCAN_WITHIN_END: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV) && (mode_q == MD_SCAN) |-> cur_ch_q <= end_ch_q); // R7
  AST_OVR_ON_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    buf_ovwr && !ctl_start |=> ovr_q); // R10
  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (rst)
    ctl_off |=> !adc_start); // R5
endmodule

// File: tb/test_adc_mode_sequencer.sv
module test_adc_mode_sequencer;
  localparam int RES_W = 10, CH_W = 4, NBUF = 10, STAB = 14, CONV = 14;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_we = 1'b0, chan_we = 1'b0, eoc_clr = 1'b0, rd_en = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [CH_W-1:0] chan_wdata = '0;
  logic [3:0] rd_addr = '0;
  logic [RES_W-1:0] rd_data, adc_result = '0;
  logic eoc, ovr, irq, adc_start, adc_done = 1'b0;
  logic [CH_W-1:0] cur_chan;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  adc_mode_sequencer i_adc_mode_sequencer (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .chan_we(chan_we), .chan_wdata(chan_wdata), .eoc_clr(eoc_clr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .eoc(eoc),
    .ovr(ovr), .irq(irq), .cur_chan(cur_chan), .adc_start(adc_start),
    .adc_done(adc_done), .adc_result(adc_result)
  );

  // converter model: result = {channel, sequence number}
  logic conv_busy = 1'b0;
  int conv_cnt = 0;
  logic [CH_W-1:0] conv_ch = '0;
  logic [5:0] seq = '0;
  always @(posedge clk) begin
    if (rst) begin
      conv_busy <= 1'b0; adc_done <= 1'b0; seq <= '0;
    end else begin
      adc_done <= 1'b0;
      if (adc_start) begin
        conv_busy <= 1'b1; conv_cnt <= CONV - 1; conv_ch <= cur_chan;
      end else if (conv_busy) begin
        if (conv_cnt == 0) begin
          conv_busy <= 1'b0; adc_done <= 1'b1;
          adc_result <= {conv_ch, seq}; seq <= seq + 1'b1;
        end else conv_cnt <= conv_cnt - 1;
      end
    end
  end

  int n_start = 0, n_done = 0;
  logic [CH_W-1:0] start_log [0:31];
  always @(posedge clk) begin
    if (!rst) begin
      if (adc_start) begin
        start_log[n_start % 32] <= cur_chan;
        n_start <= n_start + 1;
      end
      if (adc_done) n_done <= n_done + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [4:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic chan_write(input logic [CH_W-1:0] c);
    @(negedge clk); chan_we = 1'b1; chan_wdata = c;
    @(negedge clk); chan_we = 1'b0;
  endtask

  task automatic clr_eoc();
    @(negedge clk); eoc_clr = 1'b1;
    @(negedge clk); eoc_clr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [RES_W-1:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic wait_eoc(input int maxc, output bit got);
    got = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (eoc) begin got = 1'b1; break; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(eoc == 0 && ovr == 0 && irq == 0, "R1 flags", {eoc, ovr, irq}, 0);
    chk(adc_start == 0 && cur_chan == 0, "R1 start/chan", {adc_start, cur_chan}, 0);
  endtask

  task automatic t_stab_single();
    int d;
    bit got;
    logic [RES_W-1:0] v;
    chan_write(4'd5);
    ctl_write(5'b10001);
    idle(20);
    chk(n_start == 0, "R2 power-up only", n_start, 0);
    ctl_write(5'b10001);
    d = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      d++;
      if (d == 3) begin ctl_we = 1'b1; ctl_wdata = 5'b10001; end
      if (d == 4) ctl_we = 1'b0;
      if (adc_start) break;
    end
    chk(d >= STAB && d <= STAB + 1, "R2 stab delay", d, STAB);
    wait_eoc(100, got);
    chk(got && n_start == 1, "R2 held start single launch", n_start, 1);
    chk(eoc == 1 && irq == 1, "R4 eoc/irq", {eoc, irq}, 3);
    rd(4'hF, v);
    chk(v[9:6] == 4'd5, "R4 data register channel", v[9:6], 5);
  endtask

  task automatic t_fast_start();
    bit got;
    logic [RES_W-1:0] v;
    clr_eoc();
    chk(eoc == 0 && irq == 0, "R11 eoc clear", {eoc, irq}, 0);
    ctl_write(5'b00001);
    chk(adc_start == 1, "R3 immediate start", adc_start, 1);
    wait_eoc(100, got);
    chk(got && irq == 0, "R4 irq masked", irq, 0);
    rd(4'hF, v);
    chk(v[9:6] == 4'd5, "R4 second result channel", v[9:6], 5);
  endtask

  task automatic t_abort();
    bit got;
    logic [RES_W-1:0] v;
    clr_eoc();
    ctl_write(5'b00001);
    idle(5);
    chan_write(4'd7);
    wait_eoc(100, got);
    rd(4'hF, v);
    chk(got && v[9:6] == 4'd7, "R9 abort restarts on new channel", v[9:6], 7);
    chk(cur_chan == 4'd7, "R9 channel shown", cur_chan, 7);
  endtask

  task automatic t_continuous();
    bit got;
    int s;
    clr_eoc();
    ctl_write(5'b00011);
    wait_eoc(100, got);
    clr_eoc();
    wait_eoc(100, got);
    chk(got, "R5 continuous relaunch", got, 1);
    ctl_write(5'b00001);
    idle(40);
    s = n_start;
    idle(40);
    chk(n_start == s, "R5 cont clear stops", n_start, s);
  endtask

  task automatic t_power_off();
    int s;
    ctl_write(5'b00011);
    idle(20);
    ctl_write(5'b00000);
    s = n_start;
    clr_eoc();
    idle(60);
    chk(n_start == s, "R5 power off no start", n_start, s);
    chk(eoc == 0, "R5 power off no eoc", eoc, 0);
  endtask

  task automatic t_buffered();
    bit got;
    int d0;
    logic [RES_W-1:0] v;
    chan_write(4'd2);
    ctl_write(5'b01011);
    d0 = n_done;
    ctl_write(5'b01011);
    wait_eoc(400, got);
    chk(got && (n_done - d0) == NBUF, "R6 eoc on tenth", n_done - d0, NBUF);
    rd(4'd0, v);
    chk(v[9:6] == 4'd2, "R6 entry 0 channel", v[9:6], 2);
    rd(4'd9, v);
    chk(v[9:6] == 4'd2, "R6 entry 9 channel", v[9:6], 2);
    clr_eoc();
    wait_eoc(400, got);
    chk(got, "R6 refill restarts", got, 1);
    chk(ovr == 1, "R10 buffered overrun", ovr, 1);
    ctl_write(5'b01011);
    chk(ovr == 0, "R10 start write clears ovr", ovr, 0);
    ctl_write(5'b00000);
    idle(30);
  endtask

  task automatic t_scan();
    bit got, seq_ok;
    int s0;
    logic [RES_W-1:0] v;
    chan_write(4'd3);
    ctl_write(5'b00101);
    clr_eoc();
    s0 = n_start;
    ctl_write(5'b00101);
    wait_eoc(400, got);
    chk(got && (n_start - s0) == 4, "R7 scan count", n_start - s0, 4);
    seq_ok = 1'b1;
    for (int k = 0; k < 4; k++)
      if (start_log[(s0 + k) % 32] != CH_W'(k)) seq_ok = 1'b0;
    chk(seq_ok, "R7 live channel order", seq_ok, 1);
    chk(cur_chan == 4'd3, "R7 channel after scan", cur_chan, 3);
    for (int k = 0; k < 4; k++) begin
      rd(4'(k), v);
      chk(v[9:6] == 4'(k), "R7 entry channel", v[9:6], k);
    end
    clr_eoc();
    ctl_write(5'b00101);
    wait_eoc(400, got);
    chk(got && ovr == 0, "R10 read entries no overrun", ovr, 0);
  endtask

  task automatic t_cont_scan();
    bit got;
    int s0, s;
    chan_write(4'd2);
    clr_eoc();
    s0 = n_start;
    ctl_write(5'b00111);
    wait_eoc(400, got);
    clr_eoc();
    wait_eoc(400, got);
    chk(got && ovr == 1, "R10 scan overrun", ovr, 1);
    chk(start_log[(s0 + 3) % 32] == 0, "R8 pass restarts at 0", start_log[(s0 + 3) % 32], 0);
    ctl_write(5'b00101);
    idle(200);
    s = n_start;
    idle(60);
    chk(n_start == s, "R8 stop after last channel", n_start, s);
    chk(cur_chan == 4'd2 && eoc == 1, "R8 stopped at end", cur_chan, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stab_single();
    t_fast_start();
    t_abort();
    t_continuous();
    t_power_off();
    t_buffered();
    t_scan();
    t_cont_scan();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule